// File: doc/BRIEF.md
# Receive Frame Undersize Classifier

This block sits on a byte-wide receive stream whose preamble and start delimiter have already been removed. Each beat carries one byte, qualified by a valid strobe, and the first and last beats of a frame are flagged by start and end markers. The block counts the bytes of each frame and sorts the frame into one of three classes. A frame shorter than a programmable byte threshold is short. A frame at or above that threshold but under 64 bytes is a runt. Any other frame is normal.

The block also inspects the length/type and opcode bytes of every frame to pick out MAC control frames. Pause frames are the only control frames it treats as known. A configuration bit sets whether unknown control frames are forwarded or flagged for discard. The result of each frame comes out as a one-cycle pulse just after its last beat. Two saturating event counters, one for short frames and one for runt frames, can be read through a small register port and clear themselves when read.

Top module: `rx_undersize_classifier`

## Requirements
- R1: Frame length is the number of beats with `in_valid` high from the start beat through the end beat inclusive; beats with `in_valid` low are not counted, and the count saturates at 64 so that frames of any length above 64 classify as normal.
- R2: A frame whose length is less than the threshold is classified short (`cls_kind` = 1).
- R3: A frame whose length is at least the threshold and less than 64 is classified runt (`cls_kind` = 2); with a threshold of 0 no frame is short.
- R4: A frame of 64 bytes or more is classified normal (`cls_kind` = 0); `cls_kind` never takes the value 3.
- R5: The threshold register is at address 0. A write stores `reg_wdata[4:0]` and ignores bits 31:5, a read returns the stored value zero-extended, and the reset value is 8.
- R6: A frame whose bytes at offsets 12 and 13 (offset 0 = start beat) are 0x88 and 0x08 raises `cls_ctrl`; if the bytes at offsets 14 and 15 are also 0x00 and 0x01 it raises `cls_pause`. `cls_pause` is never high without `cls_ctrl`.
- R7: The discard-unknown bit is bit 0 at address 1, with reset value 0. `cls_drop` is high exactly when the frame is a control frame that is not a pause frame and the bit is 1.
- R8: `cls_valid` is high for exactly the one cycle after the clock edge that accepts the end beat, and `cls_kind`, `cls_ctrl`, `cls_pause` and `cls_drop` are valid with it.
- R9: The short counter (address 2) and the runt counter (address 3) are 16 bits wide, reset to 0, count one per classified frame of their kind, and hold at 0xFFFF instead of wrapping.
- R10: Reading address 2 or 3 (`reg_rd` high) returns the current count and clears it at that clock edge. An event of the same kind at that same edge leaves the counter at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive beat qualifier |
| in_sop | input | 1 | First byte of frame |
| in_eop | input | 1 | Last byte of frame |
| in_data | input | 8 | Receive byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears counters) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cls_valid | output | 1 | One-cycle classification pulse |
| cls_kind | output | 2 | 0 normal, 1 short, 2 runt |
| cls_ctrl | output | 1 | Frame is a MAC control frame |
| cls_pause | output | 1 | Frame is a pause frame |
| cls_drop | output | 1 | Frame should be discarded |

## Verification
The assertions watch on every cycle that a classification pulse only follows an accepted end beat, that the kind code stays legal, that pause implies control and discard implies an unknown control frame, and that a saturated counter holds unless it is read. Where each length falls relative to the threshold and to 64, which byte patterns count as control or pause, the effect of each configuration field, clear-on-read that coincides with an event, and counter saturation after sixty-five thousand frames are shown only by the bench's scenarios against its own expected values.

// File: rtl/rx_undersize_classifier.sv
module rx_undersize_classifier #(
  parameter int CW = 16,
  parameter int MIN_LEN = 64,
  parameter logic [4:0] THR_RESET = 5'd8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [7:0]  in_data,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cls_valid,
  output logic [1:0]  cls_kind,
  output logic        cls_ctrl,
  output logic        cls_pause,
  output logic        cls_drop
);
  localparam int LW = $clog2(MIN_LEN + 1);
  localparam logic [LW-1:0] LMAX = LW'(MIN_LEN);
  localparam logic [CW-1:0] CMAX = '1;

  logic [LW-1:0] cnt, idx, len_now;
  logic [3:0]    match, match_now, hit;
  logic [4:0]    thr;
  logic          disc;
  logic [CW-1:0] short_cnt, runt_cnt;

  assign idx     = in_sop ? '0 : cnt;
  assign len_now = in_sop ? LW'(1) : ((cnt == LMAX) ? LMAX : cnt + LW'(1));

  assign hit[0] = (idx == LW'(12)) && (in_data == 8'h88);
  assign hit[1] = (idx == LW'(13)) && (in_data == 8'h08);
  assign hit[2] = (idx == LW'(14)) && (in_data == 8'h00);
  assign hit[3] = (idx == LW'(15)) && (in_data == 8'h01);
  assign match_now = (in_sop ? 4'b0 : match) | hit;

  wire is_ctrl  = &match_now[1:0];
  wire is_pause = &match_now;
  wire eop_beat = in_valid && in_eop;
  wire is_short = len_now < LW'(thr);
  wire is_runt  = !is_short && (len_now < LMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      match <= '0;
    end else if (in_valid) begin
      cnt   <= len_now;
      match <= match_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_valid <= 1'b0;
      cls_kind  <= 2'd0;
      cls_ctrl  <= 1'b0;
      cls_pause <= 1'b0;
      cls_drop  <= 1'b0;
    end else begin
      cls_valid <= eop_beat;
      if (eop_beat) begin
        cls_kind  <= is_short ? 2'd1 : (is_runt ? 2'd2 : 2'd0);
        cls_ctrl  <= is_ctrl;
        cls_pause <= is_pause;
        cls_drop  <= is_ctrl && !is_pause && disc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr  <= THR_RESET;
      disc <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd0) thr  <= reg_wdata[4:0];
      if (reg_addr == 2'd1) disc <= reg_wdata[0];
    end
  end

  wire short_ev = eop_beat && is_short;
  wire runt_ev  = eop_beat && is_runt;
  wire short_rd = reg_rd && (reg_addr == 2'd2);
  wire runt_rd  = reg_rd && (reg_addr == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      short_cnt <= '0;
      runt_cnt  <= '0;
    end else begin
      if (short_rd)                           short_cnt <= CW'(short_ev);
      else if (short_ev && short_cnt != CMAX) short_cnt <= short_cnt + 1'b1;
      if (runt_rd)                            runt_cnt  <= CW'(runt_ev);
      else if (runt_ev && runt_cnt != CMAX)   runt_cnt  <= runt_cnt + 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'(thr);
      2'd1:    reg_rdata = 32'(disc);
      2'd2:    reg_rdata = 32'(short_cnt);
      default: reg_rdata = 32'(runt_cnt);
    endcase
  end
endmodule

module rx_undersize_classifier_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_eop,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic          cls_valid,
  input logic [1:0]    cls_kind,
  input logic          cls_ctrl,
  input logic          cls_pause,
  input logic          cls_drop,
  input logic [CW-1:0] short_cnt,
  input logic [CW-1:0] runt_cnt
);
  p_pulse_after_eop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop) |=> cls_valid);
  p_no_spurious_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_eop) |=> !cls_valid);
  p_legal_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> cls_kind != 2'd3);
  p_pause_is_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid && cls_pause |-> cls_ctrl);
  p_drop_unknown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid && cls_drop |-> cls_ctrl && !cls_pause);
  p_short_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (short_cnt == '1 && !(reg_rd && reg_addr == 2'd2)) |=> short_cnt == '1);
  p_runt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (runt_cnt == '1 && !(reg_rd && reg_addr == 2'd3)) |=> runt_cnt == '1);
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2) |=> short_cnt <= 1);
endmodule

bind rx_undersize_classifier rx_undersize_classifier_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .cls_valid(cls_valid),
  .cls_kind(cls_kind), .cls_ctrl(cls_ctrl), .cls_pause(cls_pause),
  .cls_drop(cls_drop), .short_cnt(short_cnt), .runt_cnt(runt_cnt)
);

// File: tb/rx_undersize_classifier_test.sv
module rx_undersize_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // len, thr, ctype(0 none,1 pause,2 unknown), disc, kind, ctrl, pause, drop
  localparam int VEC [NV][8] = '{
    '{5,  8, 0, 0, 1, 0, 0, 0},
    '{8,  8, 0, 0, 2, 0, 0, 0},
    '{7,  8, 0, 0, 1, 0, 0, 0},
    '{63, 8, 0, 0, 2, 0, 0, 0},
    '{64, 8, 0, 0, 0, 0, 0, 0},
    '{20, 31, 0, 0, 1, 0, 0, 0},
    '{31, 31, 0, 0, 2, 0, 0, 0},
    '{10, 0, 0, 0, 2, 0, 0, 0},
    '{64, 8, 1, 1, 0, 1, 1, 0},
    '{64, 8, 2, 1, 0, 1, 0, 1},
    '{64, 8, 2, 0, 0, 1, 0, 0},
    '{14, 8, 2, 1, 2, 1, 0, 1},
    '{13, 8, 2, 1, 2, 0, 0, 0}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0] in_data = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic cls_valid, cls_ctrl, cls_pause, cls_drop;
  logic [1:0] cls_kind;
  int checks = 0, failures = 0, exp_short = 0, exp_runt = 0;
  bit done = 0;

  rx_undersize_classifier uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input bit do_clr, output logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_rd = do_clr; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  function automatic logic [7:0] fbyte(input int i, input int ct);
    if (ct != 0 && i == 12) return 8'h88;
    if (ct != 0 && i == 13) return 8'h08;
    if (ct != 0 && i == 14) return 8'h00;
    if (ct != 0 && i == 15) return (ct == 1) ? 8'h01 : 8'h02;
    return 8'(i);
  endfunction

  // sends a frame; every third byte preceded by an idle beat when gaps=1
  task automatic send(input int len, input int ct, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && i % 3 == 1) begin
        @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0; in_data = 8'h88;
      end
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_eop = (i == len - 1); in_data = fbyte(i, ct);
    end
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic expect_cls(input string req, input int k, input int c, input int p, input int d);
    check(cls_valid === 1'b1, {req, " pulse"}, cls_valid, 1);
    check(cls_kind == 2'(k), {req, " kind"}, cls_kind, k);
    check(cls_ctrl == c[0] && cls_pause == p[0] && cls_drop == d[0], {req, " ctrl/pause/drop"},
          {cls_ctrl, cls_pause, cls_drop}, {c[0], p[0], d[0]});
    @(negedge clk);
    check(cls_valid === 1'b0, "R8 pulse one cycle", cls_valid, 0);
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!done && cyc < 200000) begin @(posedge clk); cyc++; end
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5 R7 R9 reset values
    rd(2'd0, 0, v); check(v == 8, "R5 threshold reset", v, 8);
    rd(2'd1, 0, v); check(v == 0, "R7 discard reset", v, 0);
    rd(2'd2, 0, v); check(v == 0, "R9 short reset", v, 0);
    rd(2'd3, 0, v); check(v == 0, "R9 runt reset", v, 0);
    check(cls_valid == 0, "R8 idle after reset", cls_valid, 0);

    // R2 R3 R4 R6 R7 table
    for (int n = 0; n < NV; n++) begin
      wr(2'd0, 32'(VEC[n][1]));
      wr(2'd1, 32'(VEC[n][3]));
      send(VEC[n][0], VEC[n][2], 0);
      expect_cls($sformatf("R2/R3/R4/R6/R7 vec%0d", n), VEC[n][4], VEC[n][5], VEC[n][6], VEC[n][7]);
      if (VEC[n][4] == 1) exp_short++;
      if (VEC[n][4] == 2) exp_runt++;
    end

    // R1 idle beats not counted: 8 bytes with gaps, thr 9 -> short; thr 8 -> runt
    wr(2'd0, 9); send(8, 0, 1); expect_cls("R1 gaps short", 1, 0, 0, 0); exp_short++;
    wr(2'd0, 8); send(8, 0, 1); expect_cls("R1 gaps runt", 2, 0, 0, 0); exp_runt++;
    // R1 saturation: long frame normal
    send(300, 0, 0); expect_cls("R1 long frame", 0, 0, 0, 0);
    // R3 single byte, threshold 1 -> runt; threshold 2 -> short
    wr(2'd0, 1); send(1, 0, 0); expect_cls("R3 one byte", 2, 0, 0, 0); exp_runt++;
    wr(2'd0, 2); send(1, 0, 0); expect_cls("R2 one byte", 1, 0, 0, 0); exp_short++;

    // R5 upper bits ignored
    wr(2'd0, 32'hFFFF_FFE5);
    rd(2'd0, 0, v); check(v == 5, "R5 upper bits ignored", v, 5);
    send(4, 0, 0); expect_cls("R5 masked threshold short", 1, 0, 0, 0); exp_short++;
    send(5, 0, 0); expect_cls("R5 masked threshold runt", 2, 0, 0, 0); exp_runt++;

    // R9 R10 counts and clear on read
    rd(2'd2, 1, v); check(v == 32'(exp_short), "R9 short count", v, exp_short);
    rd(2'd3, 1, v); check(v == 32'(exp_runt), "R9 runt count", v, exp_runt);
    rd(2'd2, 0, v); check(v == 0, "R10 short cleared", v, 0);
    rd(2'd3, 0, v); check(v == 0, "R10 runt cleared", v, 0);

    // R10 read coincides with short event
    wr(2'd0, 8);
    send(3, 0, 0); @(negedge clk);
    @(negedge clk);
    reg_addr = 2'd2; reg_rd = 1; in_valid = 1; in_sop = 1; in_eop = 1; in_data = 0;
    #1 v = reg_rdata; check(v == 1, "R10 value before clear", v, 1);
    @(negedge clk); reg_rd = 0; in_valid = 0; in_sop = 0; in_eop = 0;
    rd(2'd2, 0, v); check(v == 1, "R10 same-edge event", v, 1);
    rd(2'd2, 1, v);

    // R9 saturation: 65540 one-byte short frames back to back
    @(negedge clk); in_valid = 1; in_sop = 1; in_eop = 1; in_data = 0;
    repeat (65540) @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
    @(negedge clk);
    rd(2'd2, 0, v); check(v == 32'hFFFF, "R9 short saturates", v, 32'hFFFF);
    rd(2'd2, 1, v);
    rd(2'd2, 0, v); check(v == 0, "R10 clear after saturation", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule